// File: doc/BRIEF.md
# Battery Save-RAM Lane Adapter

This block places a byte-wide battery-backed save RAM inside the 2 MiB cartridge window that starts at 0x200000 on a 16-bit bus. A cartridge may wire its save RAM to both data lanes, to the upper (even-address) lane only, or to the lower (odd-address) lane only. The adapter turns each 16-bit bus access with byte strobes into a RAM byte index and per-lane steering. It drives 0xFF on any lane with no RAM behind it and drops writes aimed at such a lane. The RAM is held inside the block as two byte banks, one per lane.

A small mapping register, decoded in the 0xA13000 page, decides what the window shows. With its low bit clear, reads in the window return the cartridge ROM word presented on `rom_rdata_i`. With it set, reads return save RAM. RAM writes are accepted only while the register's two low bits read exactly 01, so software can map the RAM in read-only.

Read data is registered: a read request in one cycle yields `rvalid_o` and `rdata_o` in the next.

Top module: `savram_lane_adapter`

## Requirements
- R1: After reset the mapping register is 0: window reads return the ROM word and window writes leave the RAM unchanged.
- R2: The mapping register is written by a bus write in 0xA13000–0xA130FF with address bits [3:1] equal to 0 and be_i[0] set, taking wdata_i[1:0]. A write with be_i = 2'b10 (even byte only), or with another index, does not change it.
- R3: A window read (address bits [23:21] = 3'b001) returns save RAM while mapping bit 0 is 1, and returns the rom_rdata_i value sampled with the request while it is 0.
- R4: Window writes change the RAM only while mapping bits [1:0] equal 2'b01. The value 2'b11 shows RAM but drops writes.
- R5: In both-lanes mode (lane_mode_i = 2'b00 or 2'b11), for a masked offset A, bits [15:8] carry RAM byte A&~1 and bits [7:0] carry byte A|1. be_i[1] writes the upper byte from wdata_i[15:8], and be_i[0] writes the lower byte from wdata_i[7:0].
- R6: In even-lane mode (lane_mode_i = 2'b01), a read returns RAM byte A/2 in bits [15:8] and 0xFF in bits [7:0]. This includes byte reads at odd addresses. Only be_i[1] writes, and lower-lane writes are dropped.
- R7: In odd-lane mode (lane_mode_i = 2'b10), a read returns 0xFF in bits [15:8] and RAM byte A/2 in bits [7:0]. This includes byte reads at even addresses. Only be_i[0] writes, and upper-lane writes are dropped.
- R8: The window offset is the bus address masked to its low WIN_AW bits (default 10), so addresses 2^WIN_AW apart alias.
- R9: Every read request raises rvalid_o for exactly the next cycle and never on writes. Reads outside the window return 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lane_mode_i | input | 2 | RAM wiring: 00/11 both lanes, 01 even lane, 10 odd lane |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | 24 | Byte address |
| be_i | input | 2 | Byte strobes: [1] bits 15:8 (even byte), [0] bits 7:0 (odd byte) |
| wdata_i | input | 16 | Write data |
| rom_rdata_i | input | 16 | ROM word for the current address |
| rdata_o | output | 16 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |

## Verification
The assertions assume that each access is held for a single cycle with a stable address, and that lane_mode_i does not change between a read request and its returned data. The lane-fill and ROM pass-through properties judge a response from the mode, mapping state and window decode of the request cycle. The bench drives every access on the falling edge for one cycle and returns req_i low before the next. It changes the lane mode only between scenarios, when no read is outstanding, and writes every RAM location before reading it back.

// File: rtl/savram_pkg.sv
package savram_pkg;
  typedef enum logic [1:0] {
    LANE_BOTH     = 2'b00,
    LANE_EVEN     = 2'b01,
    LANE_ODD      = 2'b10,
    LANE_BOTH_ALT = 2'b11
  } lane_mode_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_RAM  = 2'b01,
    SRC_ROM  = 2'b10
  } rd_src_e;

  localparam logic [1:0] MAP_RW = 2'b01;
endpackage

// File: rtl/savram_map_reg.sv
module savram_map_reg #(
  parameter int              AW       = 24,
  parameter logic [AW-1:0]   REG_BASE = 24'hA13000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic          be_lo_i,
  input  logic [1:0]    wdata_i,
  output logic [1:0]    map_o
);
  logic page_hit, wr_hit;

  assign page_hit = addr_i[AW-1:8] == REG_BASE[AW-1:8];
  // index 0 only; byte writes land only on the odd (low) lane
  assign wr_hit   = req_i && we_i && page_hit && (addr_i[3:1] == 3'd0) && be_lo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     map_o <= '0;
    else if (wr_hit) map_o <= wdata_i;
  end
endmodule

// File: rtl/savram_lane_steer.sv
module savram_lane_steer
  import savram_pkg::*;
#(
  parameter int OFF_W = 10,
  localparam int IDX_W = OFF_W - 1
) (
  input  logic [1:0]       lane_mode_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             wr_en_i,
  input  logic [1:0]       be_i,
  output logic [1:0]       lane_en_o,
  output logic [1:0]       bank_we_o,
  output logic [IDX_W-1:0] idx_o
);
  // both lanes: byte pair at offset; single lane: byte A/2 -> same bank index
  assign idx_o = off_i[OFF_W-1:1];

  always_comb begin
    unique case (lane_mode_e'(lane_mode_i))
      LANE_EVEN: lane_en_o = 2'b10;
      LANE_ODD:  lane_en_o = 2'b01;
      default:   lane_en_o = 2'b11;
    endcase
  end

  assign bank_we_o = wr_en_i ? (be_i & lane_en_o) : 2'b00;
endmodule

// File: rtl/savram_bank.sv
module savram_bank #(
  parameter int IDX_W = 9,
  parameter int BW    = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [BW-1:0]    wd_i,
  output logic [BW-1:0]    rd_o
);
  logic [BW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[idx_i] <= wd_i;
    if (re_i) rd_o <= mem[idx_i];
  end
endmodule

// File: rtl/savram_lane_adapter.sv
module savram_lane_adapter
  import savram_pkg::*;
#(
  parameter int            AW         = 24,
  parameter int            DW         = 16,
  parameter int            WIN_AW     = 10,
  parameter int            WIN_SPAN_W = 21,
  parameter logic [AW-1:0] WIN_BASE   = 24'h200000,
  parameter logic [AW-1:0] REG_BASE   = 24'hA13000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    lane_mode_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    be_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] rom_rdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  localparam int          BW    = DW / 2;
  localparam int          IDX_W = WIN_AW - 1;
  localparam logic [BW-1:0] FILL = '1;

  logic [1:0]          map_q;
  logic                in_win, rd_req, ram_rd, ram_wr;
  logic [1:0]          lane_en, bank_we;
  logic [IDX_W-1:0]    idx;
  logic [1:0][BW-1:0]  bank_rd;
  rd_src_e             src_q;
  logic [1:0]          lane_q;
  logic [DW-1:0]       rom_q;

  assign in_win = addr_i[AW-1:WIN_SPAN_W] == WIN_BASE[AW-1:WIN_SPAN_W];
  assign rd_req = req_i && !we_i;
  assign ram_rd = rd_req && in_win && map_q[0];
  assign ram_wr = req_i && we_i && in_win && (map_q == MAP_RW);

  savram_map_reg #(.AW(AW), .REG_BASE(REG_BASE)) u_map (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .be_lo_i (be_i[0]),
    .wdata_i (wdata_i[1:0]),
    .map_o   (map_q)
  );

  savram_lane_steer #(.OFF_W(WIN_AW)) u_steer (
    .lane_mode_i (lane_mode_i),
    .off_i       (addr_i[WIN_AW-1:0]),
    .wr_en_i     (ram_wr),
    .be_i        (be_i),
    .lane_en_o   (lane_en),
    .bank_we_o   (bank_we),
    .idx_o       (idx)
  );

  // bank 1 = upper/even lane, bank 0 = lower/odd lane
  for (genvar g = 0; g < 2; g++) begin : g_bank
    savram_bank #(.IDX_W(IDX_W), .BW(BW)) u_bank (
      .clk_i (clk_i),
      .we_i  (bank_we[g]),
      .re_i  (ram_rd),
      .idx_i (idx),
      .wd_i  (wdata_i[g*BW +: BW]),
      .rd_o  (bank_rd[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      src_q    <= SRC_NONE;
      lane_q   <= 2'b00;
      rom_q    <= '0;
    end else begin
      rvalid_o <= rd_req;
      if (rd_req) begin
        lane_q <= lane_en;
        rom_q  <= rom_rdata_i;
        if (!in_win)       src_q <= SRC_NONE;
        else if (map_q[0]) src_q <= SRC_RAM;
        else               src_q <= SRC_ROM;
      end
    end
  end

  always_comb begin
    rdata_o = '1;
    unique case (src_q)
      SRC_RAM: begin
        for (int g = 0; g < 2; g++)
          rdata_o[g*BW +: BW] = lane_q[g] ? bank_rd[g] : FILL;
      end
      SRC_ROM: rdata_o = rom_q;
      default: rdata_o = '1;
    endcase
  end
endmodule

// File: rtl/savram_lane_adapter_chk.sv
module savram_lane_adapter_chk #(
  parameter int            AW         = 24,
  parameter int            DW         = 16,
  parameter int            WIN_SPAN_W = 21,
  parameter logic [AW-1:0] WIN_BASE   = 24'h200000,
  parameter logic [AW-1:0] REG_BASE   = 24'hA13000
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    lane_mode_i,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [1:0]    be_i,
  input logic [DW-1:0] rom_rdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          rvalid_o,
  input logic [1:0]    map_q,
  input logic [1:0]    bank_we
);
  localparam int BW = DW / 2;

  logic win, rd, pg;
  assign win = addr_i[AW-1:WIN_SPAN_W] == WIN_BASE[AW-1:WIN_SPAN_W];
  assign rd  = req_i && !we_i;
  assign pg  = addr_i[AW-1:8] == REG_BASE[AW-1:8];

  p_rvalid_next_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o);
  p_rvalid_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !rvalid_o);
  p_outside_fill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !win) |=> rdata_o == '1);
  p_rom_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && win && !map_q[0]) |=> rdata_o == $past(rom_rdata_i));
  p_even_fill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && win && map_q[0] && lane_mode_i == 2'b01) |=> rdata_o[BW-1:0] == '1);
  p_odd_fill_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && win && map_q[0] && lane_mode_i == 2'b10) |=> rdata_o[DW-1:BW] == '1);
  p_write_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_we != 2'b00) |-> (map_q == 2'b01 && req_i && we_i && win));
  p_even_byte_reg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && pg && be_i == 2'b10) |=> $stable(map_q));
endmodule

bind savram_lane_adapter savram_lane_adapter_chk #(
  .AW(AW), .DW(DW), .WIN_SPAN_W(WIN_SPAN_W), .WIN_BASE(WIN_BASE), .REG_BASE(REG_BASE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lane_mode_i (lane_mode_i),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .be_i        (be_i),
  .rom_rdata_i (rom_rdata_i),
  .rdata_o     (rdata_o),
  .rvalid_o    (rvalid_o),
  .map_q       (map_q),
  .bank_we     (bank_we)
);

// File: tb/savram_lane_adapter_tb.sv
`timescale 1ns/1ps
module savram_lane_adapter_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  lane_mode_i = 2'b00;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [1:0]  be_i = 2'b11;
  logic [15:0] wdata_i = '0;
  logic [15:0] rom_rdata_i;
  logic [15:0] rdata_o;
  logic        rvalid_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  function automatic logic [15:0] rom_of(logic [23:0] a);
    return a[16:1] ^ 16'h5A3C;
  endfunction
  assign rom_rdata_i = rom_of(addr_i);

  savram_lane_adapter u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .lane_mode_i(lane_mode_i), .req_i(req_i),
    .we_i(we_i), .addr_i(addr_i), .be_i(be_i), .wdata_i(wdata_i),
    .rom_rdata_i(rom_rdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [23:0] a, logic [15:0] d, logic [1:0] b);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d; be_i = b;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [23:0] a, logic [15:0] exp);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a; be_i = 2'b11;
    @(negedge clk_i);
    req_i = 1'b0;
    chk({tag, " rvalid"}, {15'd0, rvalid_o}, 16'd1);
    chk(tag, rdata_o, exp);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 rvalid in reset", {15'd0, rvalid_o}, 16'd0);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    rd_chk("R1 rom after reset", 24'h200000, rom_of(24'h200000));
    rd_chk("R1 rom after reset hi", 24'h3FFFF0, rom_of(24'h3FFFF0));
  endtask

  task automatic t_map_reg();
    lane_mode_i = 2'b00;
    bus_wr(24'hA13000, 16'h0001, 2'b11);
    bus_wr(24'h200000, 16'h1234, 2'b11);
    rd_chk("R3 ram shown", 24'h200000, 16'h1234);
    bus_wr(24'hA13000, 16'h0000, 2'b11);
    rd_chk("R3 rom shown", 24'h200000, rom_of(24'h200000));
    bus_wr(24'hA13000, 16'h0101, 2'b10);
    rd_chk("R2 even byte ignored", 24'h200000, rom_of(24'h200000));
    bus_wr(24'hA13002, 16'h0001, 2'b11);
    rd_chk("R2 index1 ignored", 24'h200000, rom_of(24'h200000));
    bus_wr(24'hA13001, 16'h0001, 2'b01);
    rd_chk("R2 odd byte write", 24'h200000, 16'h1234);
  endtask

  task automatic t_wr_gate();
    bus_wr(24'hA13000, 16'h0003, 2'b11);
    bus_wr(24'h200000, 16'hFFFF, 2'b11);
    rd_chk("R4 map 11 drops write", 24'h200000, 16'h1234);
    bus_wr(24'hA13000, 16'h0001, 2'b11);
    bus_wr(24'h200030, 16'h2222, 2'b11);
    do_reset();
    bus_wr(24'h200030, 16'h3333, 2'b11);
    rd_chk("R1 rom after 2nd reset", 24'h200030, rom_of(24'h200030));
    bus_wr(24'hA13000, 16'h0003, 2'b11);
    rd_chk("R1 write dropped after reset", 24'h200030, 16'h2222);
    bus_wr(24'hA13000, 16'h0001, 2'b11);
  endtask

  task automatic t_both();
    lane_mode_i = 2'b00;
    bus_wr(24'h200010, 16'h1122, 2'b11);
    bus_wr(24'h200010, 16'hAA00, 2'b10);
    rd_chk("R5 upper byte write", 24'h200010, 16'hAA22);
    bus_wr(24'h200011, 16'h00BB, 2'b01);
    rd_chk("R5 lower byte write", 24'h200011, 16'hAABB);
    bus_wr(24'h200012, 16'h5E00, 2'b10);
    bus_wr(24'h200013, 16'h0071, 2'b01);
    rd_chk("R5 byte order A/A+1", 24'h200012, 16'h5E71);
    lane_mode_i = 2'b11;
    rd_chk("R5 mode 11 as both", 24'h200012, 16'h5E71);
  endtask

  task automatic t_even();
    lane_mode_i = 2'b01;
    bus_wr(24'h200020, 16'hC3D4, 2'b11);
    rd_chk("R6 word read", 24'h200020, 16'hC3FF);
    bus_wr(24'h200022, 16'h9911, 2'b11);
    bus_wr(24'h200023, 16'h0077, 2'b01);
    rd_chk("R6 odd write dropped", 24'h200022, 16'h99FF);
    rd_chk("R6 odd byte read fill", 24'h200023, 16'h99FF);
  endtask

  task automatic t_odd();
    lane_mode_i = 2'b10;
    bus_wr(24'h200040, 16'h5566, 2'b11);
    rd_chk("R7 word read", 24'h200040, 16'hFF66);
    bus_wr(24'h200043, 16'h0012, 2'b01);
    bus_wr(24'h200042, 16'h3400, 2'b10);
    rd_chk("R7 even write dropped", 24'h200042, 16'hFF12);
    rd_chk("R7 even byte read fill", 24'h200040, 16'hFF66);
  endtask

  task automatic t_alias();
    lane_mode_i = 2'b00;
    bus_wr(24'h200004, 16'h4321, 2'b11);
    rd_chk("R8 alias up", 24'h200404, 16'h4321);
    bus_wr(24'h3FFC06, 16'h8765, 2'b11);
    rd_chk("R8 alias top", 24'h200006, 16'h8765);
  endtask

  task automatic t_outside();
    rd_chk("R9 reg page read", 24'hA13000, 16'hFFFF);
    rd_chk("R9 low rom read", 24'h100000, 16'hFFFF);
    @(negedge clk_i);
    chk("R9 rvalid one cycle", {15'd0, rvalid_o}, 16'd0);
    bus_wr(24'h200050, 16'h0F0F, 2'b11);
    chk("R9 no rvalid on write", {15'd0, rvalid_o}, 16'd0);
  endtask

  initial begin
    t_reset();
    t_map_reg();
    t_wr_gate();
    t_both();
    t_even();
    t_odd();
    t_alias();
    t_outside();
    repeat (2) @(negedge clk_i);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule